// File: doc/BRIEF.md
# Processor Sideband Line Controller

This block drives the legacy control lines that run from a chipset to an x86-style processor: the address-bit-20 mask, the processor init pulse, the non-maskable interrupt, the numeric-error ignore line, the interrupt line and the stop-clock request. Every line is open-drain, so the block does not output pin levels. It outputs one drive-low enable per line, and a line reads high only when its enable is clear and an external pull-up lifts it.

Four of the lines have two roles. While the platform reset is active, each of them presents one bit of a frequency strap word to the processor. After reset they carry their normal function. The init line is a fixed-length pulse. It can be restarted by the keyboard controller's reset request, and when built-in self-test support is chosen it is also held for the whole reset phase. NMI is a latched level fed by two enabled error sources, and software clears it one source at a time with a write strobe.

The system-error and I/O-check inputs, the write strobes and the request levels for ignore-error, interrupt and stop-clock must already be synchronous to `clk`. The keyboard controller's gate and reset-request inputs may be asynchronous.

Top module: `cpu_sideband_ctrl`

## Requirements
- R1: The reset phase begins at the first rising edge that samples `rst_n` low. During it, each strap line is released (drive-low enable 0) when its strap bit is 1 and driven low when the bit is 0. The bit mapping is: bit 0 to the A20 mask line, bit 1 to ignore-error, bit 2 to interrupt, bit 3 to NMI.
- R2: The reset phase ends at the first rising edge that samples `rst_n` high. From that cycle every line shows its normal function.
- R3: Outside the reset phase, the A20 mask line is driven low when the fast-gate bit is 1 or the keyboard gate input is high. The fast-gate bit is written by `fastgate_we`/`fastgate_wd` and takes effect one edge after the write. The gate input passes through a two-flop synchronizer and takes effect two edges after it changes.
- R4: A falling edge on `kbd_rst_req_n` drives the init line low for exactly 16 clock cycles. The pulse starts at the third rising edge after the input falls.
- R5: A new falling edge that arrives during a pulse restarts the 16-cycle count from the new edge.
- R6: Holding `kbd_rst_req_n` low does not start another pulse. Only falling edges trigger.
- R7: With `bist_en` = 1, the init line is driven low for the whole reset phase. With `bist_en` = 0, it is released during reset.
- R8: When a source input is high in a cycle in which its enable is 1, NMI is raised one edge later (line released high). A source whose enable is 0 has no effect.
- R9: NMI is latched and stays raised after the source drops. A write with `nmi_clr_we` clears the source status selected by `nmi_clr_src` (bit 0 system error, bit 1 I/O check) one edge later. If that source is still asserted and enabled in the write cycle, its status stays set. Clearing one source leaves the other intact.
- R10: The stop-clock line is never driven during the reset phase. Outside it, the line is driven low exactly when `stpclk_req` is 1.
- R11: Outside the reset phase, the ignore-error line is driven low when `ignne_req` is 1, and the interrupt line is released high when `intr_req` is 1 and driven low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI-domain clock |
| rst_n | input | 1 | Platform reset, active low, synchronous |
| fastgate_we | input | 1 | Write strobe for the fast-gate bit |
| fastgate_wd | input | 1 | Value written to the fast-gate bit |
| a20gate_in | input | 1 | Keyboard controller A20 gate, asynchronous, high forces mask |
| kbd_rst_req_n | input | 1 | Keyboard controller reset request, asynchronous, active low |
| serr_in | input | 1 | System-error source, synchronous, active high |
| iochk_in | input | 1 | I/O-check source, synchronous, active high |
| serr_en | input | 1 | Enable for the system-error NMI source |
| iochk_en | input | 1 | Enable for the I/O-check NMI source |
| nmi_clr_we | input | 1 | Write strobe clearing NMI source status |
| nmi_clr_src | input | 2 | Sources cleared by the write (bit 0 system error, bit 1 I/O check) |
| ignne_req | input | 1 | Ignore-error request level from the error logic |
| intr_req | input | 1 | Pending interrupt level from the interrupt controller |
| stpclk_req | input | 1 | Stop-clock request level |
| strap_bits | input | 4 | Frequency strap word presented during reset |
| bist_en | input | 1 | Hold init active through reset |
| a20m_drv_low | output | 1 | Drive-low enable, A20 mask line |
| ignne_drv_low | output | 1 | Drive-low enable, ignore-error line |
| intr_drv_low | output | 1 | Drive-low enable, interrupt line |
| nmi_drv_low | output | 1 | Drive-low enable, NMI line |
| init_drv_low | output | 1 | Drive-low enable, init line |
| stpclk_drv_low | output | 1 | Drive-low enable, stop-clock line |

## Verification
The NMI status register can receive a set and a clear for the same source in the same cycle. The bench provokes this by holding the I/O-check source asserted and enabled while it pulses the clear strobe for that source. It then expects NMI to stay raised, and to fall only after a later clear write issued once the source has dropped. A second collision happens when a new keyboard reset edge arrives while an init pulse is running. The bench judges it by sampling the init line past the point where the first pulse would have ended and again at the restarted pulse's final cycle.

// File: rtl/sideband_pkg.sv
`timescale 1ns/1ps
// sideband_pkg
// Shared constants and types for the processor sideband controller.
// Assumes the strap word order fixed in the brief: A20 mask, ignore-error,
// interrupt, NMI from bit 0 upward.
package sideband_pkg;

    localparam int STRAP_W      = 4;
    localparam int STRAP_A20M   = 0;
    localparam int STRAP_IGNNE  = 1;
    localparam int STRAP_INTR   = 2;
    localparam int STRAP_NMI    = 3;

    // Lines whose asserted function is a high level (others assert low).
    localparam logic [STRAP_W-1:0] STRAP_ACT_HIGH = 4'b1100;

    localparam int NMI_SRC_N     = 2;
    localparam int NMI_SRC_SERR  = 0;
    localparam int NMI_SRC_IOCHK = 1;

    localparam int INIT_PULSE_LEN = 16;
    localparam int SYNC_DEPTH     = 2;

    typedef logic [STRAP_W-1:0]   strap_t;
    typedef logic [NMI_SRC_N-1:0] nmi_vec_t;

endpackage

// File: rtl/sb_sync.sv
`timescale 1ns/1ps
// sb_sync
// Multi-stage flop chain bringing an asynchronous level into the clk domain.
// Assumes synchronous active-low reset; every stage resets to RESET_VAL.
module sb_sync #(
    parameter int              WIDTH     = 1,
    parameter int              STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            logic [WIDTH-1:0] r;
            if (s == 0) begin : g_first
                // first stage samples the raw input
                always_ff @(posedge clk) begin
                    if (!rst_n) r <= RESET_VAL;
                    else        r <= d;
                end
            end else begin : g_next
                // later stages shift the previous stage
                always_ff @(posedge clk) begin
                    if (!rst_n) r <= RESET_VAL;
                    else        r <= g_stage[s-1].r;
                end
            end
        end
    endgenerate

    assign q = g_stage[STAGES-1].r;

endmodule

// File: rtl/sb_init_gen.sv
`timescale 1ns/1ps
// sb_init_gen
// Synchronizes the keyboard reset request, detects its falling edge and
// produces a fixed-length init pulse; a new edge reloads the count.
// Assumes the request idles high and may change at any time.
module sb_init_gen #(
    parameter int PULSE_LEN   = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_n_async,
    output logic pulse_on
);

    localparam int CNT_W = $clog2(PULSE_LEN + 1);

    logic             req_n_s;
    logic             req_n_prev;
    logic             req_fall;
    logic [CNT_W-1:0] cnt;

    sb_sync #(
        .WIDTH    (1),
        .STAGES   (SYNC_STAGES),
        .RESET_VAL(1'b1)
    ) u_req_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (req_n_async),
        .q    (req_n_s)
    );

    // remember last synchronized level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) req_n_prev <= 1'b1;
        else        req_n_prev <= req_n_s;
    end

    assign req_fall = req_n_prev & ~req_n_s;

    // pulse length counter: reload on each falling edge, else count down
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (req_fall)   cnt <= CNT_W'(PULSE_LEN);
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign pulse_on = (cnt != '0);

endmodule

// File: rtl/sb_nmi_src.sv
`timescale 1ns/1ps
// sb_nmi_src
// Per-source latched NMI status. A source sets its bit when asserted and
// enabled; a clear strobe drops selected bits. Setting wins over clearing.
// Assumes source, enable and clear inputs are synchronous to clk.
module sb_nmi_src #(
    parameter int NUM_SRC = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_lvl,
    input  logic [NUM_SRC-1:0] src_en,
    input  logic               clr_we,
    input  logic [NUM_SRC-1:0] clr_mask,
    output logic [NUM_SRC-1:0] status,
    output logic               nmi_level
);

    generate
        for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
            logic sts;
            // hold status until cleared; a live enabled source overrides the clear
            always_ff @(posedge clk) begin
                if (!rst_n)                         sts <= 1'b0;
                else if (src_lvl[i] && src_en[i])   sts <= 1'b1;
                else if (clr_we && clr_mask[i])     sts <= 1'b0;
            end
            assign status[i] = sts;
        end
    endgenerate

    assign nmi_level = |status;

endmodule

// File: rtl/sb_pin_mux.sv
`timescale 1ns/1ps
// sb_pin_mux
// Chooses, per open-drain line, between the strap bit (reset phase) and the
// normal function, and converts to drive-low enables by line polarity.
// Assumes fn_on is the logical assertion of each line's function.
module sb_pin_mux
    import sideband_pkg::*;
(
    input  logic   in_rst,
    input  strap_t strap,
    input  strap_t fn_on,
    input  logic   init_on,
    input  logic   bist_en,
    input  logic   stpclk_on,
    output strap_t strap_drv_low,
    output logic   init_drv_low,
    output logic   stpclk_drv_low
);

    generate
        for (genvar i = 0; i < STRAP_W; i++) begin : g_line
            logic level_high;
            // wanted line level in normal function, by polarity
            assign level_high = STRAP_ACT_HIGH[i] ? fn_on[i] : ~fn_on[i];
            // strap bit during reset, function afterwards
            assign strap_drv_low[i] = in_rst ? ~strap[i] : ~level_high;
        end
    endgenerate

    // init: pulse from keyboard request, or held through reset with BIST
    assign init_drv_low   = init_on | (in_rst & bist_en);
    // stop-clock stays undriven while in reset
    assign stpclk_drv_low = ~in_rst & stpclk_on;

endmodule

// File: rtl/cpu_sideband_ctrl.sv
`timescale 1ns/1ps
// cpu_sideband_ctrl
// Top of the processor sideband controller: A20 mask, init pulse, latched
// NMI, strap presentation during reset and stop-clock gating.
// Assumes rst_n is synchronous active-low; error sources and strobes are
// synchronous to clk; keyboard gate and reset request are asynchronous.
module cpu_sideband_ctrl
    import sideband_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        fastgate_we,
    input  logic        fastgate_wd,
    input  logic        a20gate_in,
    input  logic        kbd_rst_req_n,
    input  logic        serr_in,
    input  logic        iochk_in,
    input  logic        serr_en,
    input  logic        iochk_en,
    input  logic        nmi_clr_we,
    input  logic [1:0]  nmi_clr_src,
    input  logic        ignne_req,
    input  logic        intr_req,
    input  logic        stpclk_req,
    input  logic [3:0]  strap_bits,
    input  logic        bist_en,
    output logic        a20m_drv_low,
    output logic        ignne_drv_low,
    output logic        intr_drv_low,
    output logic        nmi_drv_low,
    output logic        init_drv_low,
    output logic        stpclk_drv_low
);

    logic     in_rst;
    logic     fastgate_q;
    logic     a20gate_s;
    logic     init_on;
    logic     nmi_level;
    nmi_vec_t nmi_status;
    strap_t   fn_on;
    strap_t   strap_drv_low;

    // reset-phase flag: set by reset, cleared on first edge out of reset
    always_ff @(posedge clk) begin
        if (!rst_n) in_rst <= 1'b1;
        else        in_rst <= 1'b0;
    end

    // fast-gate bit written by its strobe
    always_ff @(posedge clk) begin
        if (!rst_n)           fastgate_q <= 1'b0;
        else if (fastgate_we) fastgate_q <= fastgate_wd;
    end

    sb_sync #(
        .WIDTH    (1),
        .STAGES   (SYNC_DEPTH),
        .RESET_VAL(1'b0)
    ) u_a20_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (a20gate_in),
        .q    (a20gate_s)
    );

    sb_init_gen #(
        .PULSE_LEN  (INIT_PULSE_LEN),
        .SYNC_STAGES(SYNC_DEPTH)
    ) u_init (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_n_async(kbd_rst_req_n),
        .pulse_on   (init_on)
    );

    sb_nmi_src #(
        .NUM_SRC(NMI_SRC_N)
    ) u_nmi (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_lvl  ({iochk_in, serr_in}),
        .src_en   ({iochk_en, serr_en}),
        .clr_we   (nmi_clr_we),
        .clr_mask (nmi_clr_src),
        .status   (nmi_status),
        .nmi_level(nmi_level)
    );

    // gather each strap line's normal-function assertion
    always_comb begin
        fn_on              = '0;
        fn_on[STRAP_A20M]  = fastgate_q | a20gate_s;
        fn_on[STRAP_IGNNE] = ignne_req;
        fn_on[STRAP_INTR]  = intr_req;
        fn_on[STRAP_NMI]   = nmi_level;
    end

    sb_pin_mux u_mux (
        .in_rst        (in_rst),
        .strap         (strap_bits),
        .fn_on         (fn_on),
        .init_on       (init_on),
        .bist_en       (bist_en),
        .stpclk_on     (stpclk_req),
        .strap_drv_low (strap_drv_low),
        .init_drv_low  (init_drv_low),
        .stpclk_drv_low(stpclk_drv_low)
    );

    assign a20m_drv_low  = strap_drv_low[STRAP_A20M];
    assign ignne_drv_low = strap_drv_low[STRAP_IGNNE];
    assign intr_drv_low  = strap_drv_low[STRAP_INTR];
    assign nmi_drv_low   = strap_drv_low[STRAP_NMI];

endmodule

// File: rtl/cpu_sideband_ctrl_chk.sv
`timescale 1ns/1ps
// cpu_sideband_ctrl_chk
// Property checker for cpu_sideband_ctrl, observing only its ports.
// Assumes it is attached by the bind statement at the end of this file.
module cpu_sideband_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       fastgate_we,
    input logic       fastgate_wd,
    input logic       serr_in,
    input logic       iochk_in,
    input logic       serr_en,
    input logic       iochk_en,
    input logic       nmi_clr_we,
    input logic       ignne_req,
    input logic       intr_req,
    input logic       stpclk_req,
    input logic [3:0] strap_bits,
    input logic       bist_en,
    input logic       a20m_drv_low,
    input logic       ignne_drv_low,
    input logic       intr_drv_low,
    input logic       nmi_drv_low,
    input logic       init_drv_low,
    input logic       stpclk_drv_low
);

    logic seen_edge = 1'b0;
    logic prev_rst_low = 1'b0;

    // track whether the previous edge sampled reset
    always_ff @(posedge clk) begin
        seen_edge    <= 1'b1;
        prev_rst_low <= !rst_n;
    end

    // reset-phase and normal-phase line checks at each edge
    always @(posedge clk) begin
        if (seen_edge && prev_rst_low) begin
            a_r1_strap_pins: assert (a20m_drv_low == !strap_bits[0] &&
                                     ignne_drv_low == !strap_bits[1] &&
                                     intr_drv_low == !strap_bits[2] &&
                                     nmi_drv_low == !strap_bits[3]);
            a_r7_bist_init: assert (!bist_en || init_drv_low);
            a_r10_stpclk_float: assert (!stpclk_drv_low);
        end
        if (seen_edge && !prev_rst_low) begin
            a_r10_stpclk_follow: assert (stpclk_drv_low == stpclk_req);
            a_r11_ignne_intr: assert (ignne_drv_low == ignne_req &&
                                      intr_drv_low == !intr_req);
        end
    end

    a_r3_fastgate: assert property (@(posedge clk) disable iff (!rst_n)
        (fastgate_we && fastgate_wd) |=> a20m_drv_low);

    a_r8_nmi_set: assert property (@(posedge clk) disable iff (!rst_n)
        ((serr_in && serr_en) || (iochk_in && iochk_en)) |=> !nmi_drv_low);

    a_r9_nmi_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !nmi_drv_low && !nmi_clr_we) |=> !nmi_drv_low);

endmodule

bind cpu_sideband_ctrl cpu_sideband_ctrl_chk i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .fastgate_we   (fastgate_we),
    .fastgate_wd   (fastgate_wd),
    .serr_in       (serr_in),
    .iochk_in      (iochk_in),
    .serr_en       (serr_en),
    .iochk_en      (iochk_en),
    .nmi_clr_we    (nmi_clr_we),
    .ignne_req     (ignne_req),
    .intr_req      (intr_req),
    .stpclk_req    (stpclk_req),
    .strap_bits    (strap_bits),
    .bist_en       (bist_en),
    .a20m_drv_low  (a20m_drv_low),
    .ignne_drv_low (ignne_drv_low),
    .intr_drv_low  (intr_drv_low),
    .nmi_drv_low   (nmi_drv_low),
    .init_drv_low  (init_drv_low),
    .stpclk_drv_low(stpclk_drv_low)
);

// File: tb/test_cpu_sideband_ctrl.sv
`timescale 1ns/1ps
// test_cpu_sideband_ctrl
// Scoreboard bench: driver code queues expected line values with a due
// cycle; a monitor at each falling edge compares and retires them.
module test_cpu_sideband_ctrl;

    localparam int P_A20 = 0;
    localparam int P_INIT = 1;
    localparam int P_IGNNE = 2;
    localparam int P_INTR = 3;
    localparam int P_NMI = 4;
    localparam int P_STP = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fastgate_we = 1'b0, fastgate_wd = 1'b0, a20gate_in = 1'b0;
    logic kbd_rst_req_n = 1'b1;
    logic serr_in = 1'b0, iochk_in = 1'b0, serr_en = 1'b0, iochk_en = 1'b0;
    logic nmi_clr_we = 1'b0;
    logic [1:0] nmi_clr_src = 2'b00;
    logic ignne_req = 1'b0, intr_req = 1'b0, stpclk_req = 1'b1;
    logic [3:0] strap_bits = 4'b0101;
    logic bist_en = 1'b1;
    logic a20m_drv_low, ignne_drv_low, intr_drv_low, nmi_drv_low;
    logic init_drv_low, stpclk_drv_low;

    typedef struct {
        int    due;
        int    idx;
        logic  val;
        string req;
    } exp_t;

    exp_t sb_q[$];
    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    logic [5:0] obs;

    always #2.5 clk = ~clk;

    cpu_sideband_ctrl i_cpu_sideband_ctrl (
        .clk(clk), .rst_n(rst_n), .fastgate_we(fastgate_we),
        .fastgate_wd(fastgate_wd), .a20gate_in(a20gate_in),
        .kbd_rst_req_n(kbd_rst_req_n), .serr_in(serr_in), .iochk_in(iochk_in),
        .serr_en(serr_en), .iochk_en(iochk_en), .nmi_clr_we(nmi_clr_we),
        .nmi_clr_src(nmi_clr_src), .ignne_req(ignne_req), .intr_req(intr_req),
        .stpclk_req(stpclk_req), .strap_bits(strap_bits), .bist_en(bist_en),
        .a20m_drv_low(a20m_drv_low), .ignne_drv_low(ignne_drv_low),
        .intr_drv_low(intr_drv_low), .nmi_drv_low(nmi_drv_low),
        .init_drv_low(init_drv_low), .stpclk_drv_low(stpclk_drv_low)
    );

    assign obs = {stpclk_drv_low, nmi_drv_low, intr_drv_low,
                  ignne_drv_low, init_drv_low, a20m_drv_low};

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: retire every expectation due at this falling edge
    always @(negedge clk) begin
        for (int k = sb_q.size() - 1; k >= 0; k--) begin
            if (sb_q[k].due == cyc) begin
                checks++;
                if (obs[sb_q[k].idx] !== sb_q[k].val) begin
                    errors++;
                    $display("FAIL %s: line %0d actual=%b expected=%b cycle %0d",
                             sb_q[k].req, sb_q[k].idx, obs[sb_q[k].idx],
                             sb_q[k].val, cyc);
                end
                sb_q.delete(k);
            end
        end
    end

    task automatic expect_at(input int d, input int idx, input logic v,
                             input string req);
        exp_t e;
        e.due = cyc + d;
        e.idx = idx;
        e.val = v;
        e.req = req;
        sb_q.push_back(e);
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic expect_idle(input string req);
        expect_at(1, P_A20, 1'b0, req);
        expect_at(1, P_IGNNE, 1'b0, req);
        expect_at(1, P_INTR, 1'b1, req);
        expect_at(1, P_NMI, 1'b1, req);
        expect_at(1, P_INIT, 1'b0, req);
        expect_at(1, P_STP, stpclk_req, req);
    endtask

    task automatic expect_strap(input string req);
        expect_at(2, P_A20, ~strap_bits[0], req);
        expect_at(2, P_IGNNE, ~strap_bits[1], req);
        expect_at(2, P_INTR, ~strap_bits[2], req);
        expect_at(2, P_NMI, ~strap_bits[3], req);
        expect_at(2, P_INIT, bist_en, "R7");
        expect_at(2, P_STP, 1'b0, "R10");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // watchdog
    initial begin
        #500000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual=expired expected=completion");
        finish_run();
    end

    // driver
    initial begin
        // R1 R7 R10: first reset, strap 0101 with BIST
        tick(1);
        expect_strap("R1");
        tick(4);
        rst_n = 1'b1;
        expect_idle("R2");
        tick(3);

        // R1 R7: second reset, strap 1010 without BIST
        rst_n = 1'b0;
        strap_bits = 4'b1010;
        bist_en = 1'b0;
        expect_strap("R1");
        tick(4);
        rst_n = 1'b1;
        expect_idle("R2");
        tick(3);

        // R3: fast-gate write, then keyboard gate through the synchronizer
        fastgate_we = 1'b1; fastgate_wd = 1'b1;
        expect_at(1, P_A20, 1'b1, "R3");
        tick(1);
        fastgate_we = 1'b0;
        tick(2);
        fastgate_we = 1'b1; fastgate_wd = 1'b0;
        expect_at(1, P_A20, 1'b0, "R3");
        tick(1);
        fastgate_we = 1'b0;
        a20gate_in = 1'b1;
        expect_at(1, P_A20, 1'b0, "R3");
        expect_at(2, P_A20, 1'b1, "R3");
        tick(3);
        a20gate_in = 1'b0;
        expect_at(2, P_A20, 1'b0, "R3");
        tick(3);

        // R11 R10: pass-through lines outside reset
        ignne_req = 1'b1; intr_req = 1'b1;
        expect_at(1, P_IGNNE, 1'b1, "R11");
        expect_at(1, P_INTR, 1'b0, "R11");
        tick(2);
        ignne_req = 1'b0; intr_req = 1'b0; stpclk_req = 1'b0;
        expect_at(1, P_IGNNE, 1'b0, "R11");
        expect_at(1, P_INTR, 1'b1, "R11");
        expect_at(1, P_STP, 1'b0, "R10");
        tick(2);
        stpclk_req = 1'b1;
        expect_at(1, P_STP, 1'b1, "R10");
        tick(2);

        // R8: disabled source is ignored, enabled source raises NMI
        serr_in = 1'b1;
        expect_at(1, P_NMI, 1'b1, "R8");
        expect_at(3, P_NMI, 1'b1, "R8");
        tick(3);
        serr_en = 1'b1;
        expect_at(1, P_NMI, 1'b0, "R8");
        tick(2);
        // R9: latched after the source drops, then cleared
        serr_in = 1'b0;
        expect_at(3, P_NMI, 1'b0, "R9");
        tick(3);
        nmi_clr_we = 1'b1; nmi_clr_src = 2'b01;
        expect_at(1, P_NMI, 1'b1, "R9");
        tick(1);
        nmi_clr_we = 1'b0;
        tick(2);

        // R9: set and clear collide on the I/O-check source
        iochk_en = 1'b1; iochk_in = 1'b1;
        expect_at(1, P_NMI, 1'b0, "R8");
        tick(2);
        nmi_clr_we = 1'b1; nmi_clr_src = 2'b10;
        expect_at(1, P_NMI, 1'b0, "R9");
        expect_at(2, P_NMI, 1'b0, "R9");
        tick(1);
        nmi_clr_we = 1'b0; iochk_in = 1'b0;
        expect_at(2, P_NMI, 1'b0, "R9");
        tick(2);
        // R9: clearing system error leaves I/O-check status raised
        nmi_clr_we = 1'b1; nmi_clr_src = 2'b01;
        expect_at(1, P_NMI, 1'b0, "R9");
        tick(1);
        nmi_clr_src = 2'b10;
        expect_at(1, P_NMI, 1'b1, "R9");
        tick(1);
        nmi_clr_we = 1'b0;
        tick(2);

        // R4 R6: single pulse, request held low afterwards
        kbd_rst_req_n = 1'b0;
        expect_at(2, P_INIT, 1'b0, "R4");
        expect_at(3, P_INIT, 1'b1, "R4");
        expect_at(18, P_INIT, 1'b1, "R4");
        expect_at(19, P_INIT, 1'b0, "R4");
        expect_at(30, P_INIT, 1'b0, "R6");
        tick(35);
        kbd_rst_req_n = 1'b1;
        tick(4);

        // R5: second falling edge restarts the count
        kbd_rst_req_n = 1'b0;
        expect_at(3, P_INIT, 1'b1, "R5");
        tick(5);
        kbd_rst_req_n = 1'b1;
        tick(3);
        kbd_rst_req_n = 1'b0;
        expect_at(11, P_INIT, 1'b1, "R5");
        expect_at(18, P_INIT, 1'b1, "R5");
        expect_at(19, P_INIT, 1'b0, "R5");
        tick(25);
        kbd_rst_req_n = 1'b1;
        tick(5);

        checks++;
        if (sb_q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard: actual=%0d pending expected=0", sb_q.size());
        end
        finish_run();
    end

endmodule